// File: doc/BRIEF.md
# Character-Row Display Address Generator

This block keeps the programmable register set of a character-row display controller and turns it into a running video memory address. The CPU reaches the registers through two ports in an I/O window. A write to an even port chooses a register, and the matching odd port writes or reads the chosen register. On the video side, a character-clock enable moves a column counter forward. A frame-start pulse reloads the address counters from the start address held in the registers.

The framebuffer is a bitmap built from character-cell rows. The memory address `ma` and the raster row counter `ra` do not form a linear address. They are interleaved: the low six bits of `ma` form the bottom of the address, the low two bits of `ra` sit above them, and `ma[11:6]` forms the top. Every raster line of a character row reads from the same row base. When the last raster line of the row ends, the base moves forward by the number of displayed characters.

Top module: `cellrow_crtc`

## Requirements
- R1: A write (`cpu_we_i` high) to an even port in 0x70..0x7E loads the register index from `cpu_wdata_i[4:0]`. The change takes effect at the next clock edge.
- R2: A write to an odd port in 0x71..0x7F stores `cpu_wdata_i` into the register chosen by the index. While `cpu_port_i` is an odd port in that window, `cpu_rdata_o` shows the chosen register; for any other port it reads 0x00.
- R3: Writes to ports outside 0x70..0x7F, and port activity with `cpu_we_i` low, change no register and do not change the index.
- R4: `vaddr_o` = {ma[11:6], ra[1:0], ma[5:0]}.
- R5: `frame_start_i` loads ma and the row base with {reg12[5:0], reg13} and clears the column, ra and the character-row count. It takes priority over `char_en_i` in the same cycle.
- R6: A line ends on a `char_en_i` cycle where the column equals register 0; the column then returns to 0. If ra equals register 9 (bits 4:0), ra goes to 0, the row base advances by register 1, ma takes the new base and the character-row count increments, saturating at 255. Otherwise ra increments and ma returns to the row base.
- R7: `de_o` is high only while the column is below register 1 and the character-row count is below register 6. On each `char_en_i` cycle that is not a line end, the column increments, and ma increments when `de_o` is high.
- R8: After reset, all registers, the index, the column, ra, the row count and ma are zero, so `de_o`, `ra_o` and `vaddr_o` are zero.
- R9: When the index is 18 or above, a data-port write changes nothing and a data-port read returns 0x00.
- R10: A register write in the same cycle as a counter step does not affect that step. The step uses the register value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_port_i | input | 8 | CPU I/O port number |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | Read data of the selected register |
| char_en_i | input | 1 | Character-clock enable |
| frame_start_i | input | 1 | Frame-start pulse |
| vaddr_o | output | 14 | Interleaved video memory address |
| ra_o | output | 5 | Raster row within the character row |
| de_o | output | 1 | Display enable |

## Verification
The CPU can rewrite a geometry register in the same cycle that the scan counters consume it. The case of most interest is a write to register 1 or register 9 landing on the clock edge that ends the last raster line of a character row. The bench steps its model to that exact column and row, then issues the write together with `char_en_i`. It expects the new row base to be the old base plus the old character count. The random phase keeps producing such overlaps, along with frame starts that coincide with character enables, and compares every output with a reference model that applies writes after the counter step.

// File: rtl/cellrow_pkg.sv
`timescale 1ns/1ps
package cellrow_pkg;
  parameter int MA_W = 14;
  parameter int RA_W = 5;

  localparam int IDX_HTOTAL = 0;
  localparam int IDX_HDISP  = 1;
  localparam int IDX_VDISP  = 6;
  localparam int IDX_MAXRAS = 9;
  localparam int IDX_STARTH = 12;
  localparam int IDX_STARTL = 13;

  typedef struct packed {
    logic [7:0]      htotal;
    logic [7:0]      hdisp;
    logic [7:0]      vdisp;
    logic [RA_W-1:0] maxras;
    logic [MA_W-1:0] start;
  } geom_t;
endpackage

// File: rtl/cellrow_regfile.sv
`timescale 1ns/1ps
module cellrow_regfile
  import cellrow_pkg::*;
#(
  parameter int         NUM_REGS  = 18,
  parameter int         IDX_W     = 5,
  parameter logic [3:0] PORT_HIGH = 4'h7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       cpu_port_i,
  input  logic             cpu_we_i,
  input  logic [7:0]       cpu_wdata_i,
  output logic [7:0]       cpu_rdata_o,
  output logic [IDX_W-1:0] idx_o,
  output geom_t            geom_o
);
  localparam logic [IDX_W:0] NUM_L = NUM_REGS[IDX_W:0];

  logic [7:0]       regs_q [NUM_REGS];
  logic [IDX_W-1:0] idx_q;
  logic             in_win, is_data, idx_ok;

  assign in_win  = (cpu_port_i[7:4] == PORT_HIGH);
  assign is_data = in_win & cpu_port_i[0];
  assign idx_ok  = ({1'b0, idx_q} < NUM_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (cpu_we_i && in_win) begin
      if (!cpu_port_i[0]) idx_q <= cpu_wdata_i[IDX_W-1:0];
      else if (idx_ok)    regs_q[idx_q] <= cpu_wdata_i;
    end
  end

  assign cpu_rdata_o = (is_data && idx_ok) ? regs_q[idx_q] : 8'h00;
  assign idx_o       = idx_q;

  always_comb begin
    geom_o.htotal = regs_q[IDX_HTOTAL];
    geom_o.hdisp  = regs_q[IDX_HDISP];
    geom_o.vdisp  = regs_q[IDX_VDISP];
    geom_o.maxras = regs_q[IDX_MAXRAS][RA_W-1:0];
    geom_o.start  = {regs_q[IDX_STARTH][MA_W-9:0], regs_q[IDX_STARTL]};
  end
endmodule

// File: rtl/cellrow_scan.sv
`timescale 1ns/1ps
module cellrow_scan
  import cellrow_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int ROW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             char_en_i,
  input  logic             frame_start_i,
  input  geom_t            geom_i,
  output logic [MA_W-1:0]  ma_o,
  output logic [RA_W-1:0]  ra_o,
  output logic [COL_W-1:0] col_o,
  output logic             de_o
);
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [RA_W-1:0]  ra_q;
  logic [MA_W-1:0]  ma_q, base_q, next_base;
  logic             line_end, last_ras;

  assign line_end  = (col_q == geom_i.htotal);
  assign last_ras  = (ra_q == geom_i.maxras);
  assign next_base = base_q + {{(MA_W-8){1'b0}}, geom_i.hdisp};
  assign de_o      = (col_q < geom_i.hdisp) && (row_q < geom_i.vdisp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      row_q  <= '0;
      ra_q   <= '0;
      ma_q   <= '0;
      base_q <= '0;
    end else if (frame_start_i) begin
      col_q  <= '0;
      row_q  <= '0;
      ra_q   <= '0;
      ma_q   <= geom_i.start;
      base_q <= geom_i.start;
    end else if (char_en_i) begin
      if (line_end) begin
        col_q <= '0;
        if (last_ras) begin
          ra_q   <= '0;
          base_q <= next_base;
          ma_q   <= next_base;
          if (row_q != '1) row_q <= row_q + 1'b1;
        end else begin
          ra_q <= ra_q + 1'b1;
          ma_q <= base_q;
        end
      end else begin
        col_q <= col_q + 1'b1;
        if (de_o) ma_q <= ma_q + 1'b1;
      end
    end
  end

  assign ma_o  = ma_q;
  assign ra_o  = ra_q;
  assign col_o = col_q;
endmodule

// File: rtl/cellrow_vaddr_map.sv
`timescale 1ns/1ps
module cellrow_vaddr_map #(
  parameter int VADDR_W   = 14,
  parameter int RA_ADDR_W = 2,
  parameter int LO_W      = 6,
  localparam int MAU_W    = VADDR_W - RA_ADDR_W
) (
  input  logic [MAU_W-1:0]     ma_i,
  input  logic [RA_ADDR_W-1:0] ra_i,
  output logic [VADDR_W-1:0]   vaddr_o
);
  // raster bits sit between the low and high halves of ma
  assign vaddr_o = {ma_i[MAU_W-1:LO_W], ra_i, ma_i[LO_W-1:0]};
endmodule

// File: rtl/cellrow_crtc.sv
`timescale 1ns/1ps
module cellrow_crtc
  import cellrow_pkg::*;
#(
  parameter int NUM_REGS  = 18,
  parameter int IDX_W     = 5,
  parameter int VADDR_W   = 14,
  parameter int RA_ADDR_W = 2,
  parameter int LO_W      = 6,
  parameter int COL_W     = 8,
  parameter int ROW_W     = 8,
  localparam int MAU_W    = VADDR_W - RA_ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [7:0]         cpu_port_i,
  input  logic               cpu_we_i,
  input  logic [7:0]         cpu_wdata_i,
  output logic [7:0]         cpu_rdata_o,
  input  logic               char_en_i,
  input  logic               frame_start_i,
  output logic [VADDR_W-1:0] vaddr_o,
  output logic [RA_W-1:0]    ra_o,
  output logic               de_o
);
  geom_t            geom;
  logic [IDX_W-1:0] reg_idx;
  logic [MA_W-1:0]  scan_ma;
  logic [COL_W-1:0] scan_col;

  cellrow_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni, .cpu_port_i, .cpu_we_i, .cpu_wdata_i, .cpu_rdata_o,
    .idx_o(reg_idx), .geom_o(geom)
  );

  cellrow_scan #(.COL_W(COL_W), .ROW_W(ROW_W)) u_scan (
    .clk_i, .rst_ni, .char_en_i, .frame_start_i, .geom_i(geom),
    .ma_o(scan_ma), .ra_o, .col_o(scan_col), .de_o
  );

  cellrow_vaddr_map #(.VADDR_W(VADDR_W), .RA_ADDR_W(RA_ADDR_W), .LO_W(LO_W)) u_map (
    .ma_i(scan_ma[MAU_W-1:0]), .ra_i(ra_o[RA_ADDR_W-1:0]), .vaddr_o
  );
endmodule

// File: rtl/cellrow_crtc_chk.sv
`timescale 1ns/1ps
module cellrow_crtc_chk
  import cellrow_pkg::*;
#(
  parameter int NUM_REGS = 18,
  parameter int IDX_W    = 5,
  parameter int COL_W    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       cpu_port_i,
  input logic             cpu_we_i,
  input logic [7:0]       cpu_wdata_i,
  input logic [7:0]       cpu_rdata_o,
  input logic             char_en_i,
  input logic             frame_start_i,
  input logic [RA_W-1:0]  ra_o,
  input logic             de_o,
  input logic [IDX_W-1:0] idx_i,
  input logic [7:0]       htotal_i,
  input logic [7:0]       hdisp_i,
  input logic [7:0]       vdisp_i,
  input logic [RA_W-1:0]  maxras_i,
  input logic [MA_W-1:0]  start_i,
  input logic [MA_W-1:0]  ma_i,
  input logic [COL_W-1:0] col_i
);
  localparam logic [IDX_W:0] NUM_L = NUM_REGS[IDX_W:0];

  logic idx_port, dat_port, step, eol;
  assign idx_port = (cpu_port_i[7:4] == 4'h7) && !cpu_port_i[0];
  assign dat_port = (cpu_port_i[7:4] == 4'h7) && cpu_port_i[0];
  assign step     = char_en_i && !frame_start_i;
  assign eol      = (col_i == htotal_i);

  p_idx_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i && idx_port |=> idx_i == $past(cpu_wdata_i[IDX_W-1:0]));

  p_wr_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && dat_port && ({1'b0, idx_i} < NUM_L)) ##1 (dat_port && !cpu_we_i)
    |-> cpu_rdata_o == $past(cpu_wdata_i));

  p_frame_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (ra_o == '0) && (ma_i == $past(start_i)));

  p_ra_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && !eol |=> $stable(ra_o));

  p_ra_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && eol && (ra_o == maxras_i) |=> ra_o == '0);

  p_ma_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && !eol && de_o |=> ma_i == $past(ma_i) + 1'b1);

  p_de_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (hdisp_i != 8'h00) && (vdisp_i != 8'h00));
endmodule

bind cellrow_crtc cellrow_crtc_chk #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .COL_W(COL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_port_i(cpu_port_i), .cpu_we_i(cpu_we_i),
  .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o), .char_en_i(char_en_i),
  .frame_start_i(frame_start_i), .ra_o(ra_o), .de_o(de_o), .idx_i(reg_idx),
  .htotal_i(geom.htotal), .hdisp_i(geom.hdisp), .vdisp_i(geom.vdisp),
  .maxras_i(geom.maxras), .start_i(geom.start), .ma_i(scan_ma), .col_i(scan_col)
);

// File: tb/cellrow_crtc_tb.sv
`timescale 1ns/1ps
module cellrow_crtc_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  cpu_port_i = 8'h00;
  logic        cpu_we_i = 1'b0;
  logic [7:0]  cpu_wdata_i = 8'h00;
  logic [7:0]  cpu_rdata_o;
  logic        char_en_i = 1'b0;
  logic        frame_start_i = 1'b0;
  logic [13:0] vaddr_o;
  logic [4:0]  ra_o;
  logic        de_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cellrow_crtc u_dut (
    .clk_i(clk), .rst_ni, .cpu_port_i, .cpu_we_i, .cpu_wdata_i, .cpu_rdata_o,
    .char_en_i, .frame_start_i, .vaddr_o, .ra_o, .de_o
  );

  // reference model state
  logic [7:0]  m_regs [18];
  logic [4:0]  m_idx;
  logic [7:0]  m_col, m_row;
  logic [4:0]  m_ra;
  logic [13:0] m_ma, m_base;

  function automatic logic [13:0] map_addr(logic [13:0] ma, logic [4:0] ra);
    return {ma[11:6], ra[1:0], ma[5:0]};
  endfunction

  function automatic logic m_de();
    return (m_col < m_regs[1]) && (m_row < m_regs[6]);
  endfunction

  function automatic logic [7:0] m_rdata(logic [7:0] port);
    if (port[7:4] == 4'h7 && port[0] && m_idx < 5'd18) return m_regs[m_idx];
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 18; i++) m_regs[i] = 8'h00;
    m_idx = '0; m_col = '0; m_row = '0; m_ra = '0; m_ma = '0; m_base = '0;
  endtask

  task automatic model_edge(logic [7:0] port, logic we, logic [7:0] wd, logic ce, logic fs);
    logic de_now;
    de_now = m_de();
    if (fs) begin
      m_col = '0; m_ra = '0; m_row = '0;
      m_ma = {m_regs[12][5:0], m_regs[13]};
      m_base = m_ma;
    end else if (ce) begin
      if (m_col == m_regs[0]) begin
        m_col = '0;
        if (m_ra == m_regs[9][4:0]) begin
          m_ra = '0;
          m_base = m_base + {6'd0, m_regs[1]};
          m_ma = m_base;
          if (m_row != 8'hFF) m_row = m_row + 8'd1;
        end else begin
          m_ra = m_ra + 5'd1;
          m_ma = m_base;
        end
      end else begin
        if (de_now) m_ma = m_ma + 14'd1;
        m_col = m_col + 8'd1;
      end
    end
    if (we && port[7:4] == 4'h7) begin
      if (!port[0]) m_idx = wd[4:0];
      else if (m_idx < 5'd18) m_regs[m_idx] = wd;
    end
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R4", "vaddr_o", 32'(vaddr_o), 32'(map_addr(m_ma, m_ra)));
    chk("R6", "ra_o", 32'(ra_o), 32'(m_ra));
    chk("R7", "de_o", 32'(de_o), 32'(m_de()));
    chk("R2", "cpu_rdata_o", 32'(cpu_rdata_o), 32'(m_rdata(cpu_port_i)));
  endtask

  task automatic cyc(logic [7:0] port, logic we, logic [7:0] wd, logic ce, logic fs);
    @(negedge clk);
    cpu_port_i = port; cpu_we_i = we; cpu_wdata_i = wd;
    char_en_i = ce; frame_start_i = fs;
    @(posedge clk);
    model_edge(port, we, wd, ce, fs);
    #1;
    check_all();
  endtask

  task automatic wr_reg(logic [4:0] idx, logic [7:0] val);
    cyc(8'h70, 1'b1, {3'b000, idx}, 1'b0, 1'b0);
    cyc(8'h71, 1'b1, val, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [13:0] exp_ma;
    logic [7:0]  old_r1;
    int unsigned seed;
    seed = $urandom(32'h5EED_C0DE);
    model_reset();
    cpu_port_i = 8'h71;
    #12;
    // R8: reset state
    chk("R8", "vaddr_o", 32'(vaddr_o), 32'h0);
    chk("R8", "de_o", 32'(de_o), 32'h0);
    chk("R8", "ra_o", 32'(ra_o), 32'h0);
    chk("R8", "cpu_rdata_o", 32'(cpu_rdata_o), 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1: index from data bits 4:0 via any even port
    cyc(8'h7A, 1'b1, 8'hE5, 1'b0, 1'b0);
    cyc(8'h7F, 1'b1, 8'h3C, 1'b0, 1'b0);
    cyc(8'h73, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R1", "reg5 readback", 32'(cpu_rdata_o), 32'h3C);

    // R3: out-of-window write and strobe-low access change nothing
    cyc(8'h81, 1'b1, 8'h99, 1'b0, 1'b0);
    cyc(8'h6F, 1'b1, 8'h99, 1'b0, 1'b0);
    cyc(8'h71, 1'b0, 8'h11, 1'b0, 1'b0);
    cyc(8'h70, 1'b0, 8'h02, 1'b0, 1'b0);
    cyc(8'h75, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R3", "reg5 after ignored writes", 32'(cpu_rdata_o), 32'h3C);
    cyc(8'h20, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R2", "rdata outside window", 32'(cpu_rdata_o), 32'h0);

    // R9: index beyond the register set
    cyc(8'h70, 1'b1, 8'h14, 1'b0, 1'b0);
    cyc(8'h71, 1'b1, 8'h55, 1'b0, 1'b0);
    chk("R9", "rdata idx20", 32'(cpu_rdata_o), 32'h0);
    cyc(8'h70, 1'b1, 8'h05, 1'b0, 1'b0);
    cyc(8'h71, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R9", "reg5 untouched", 32'(cpu_rdata_o), 32'h3C);

    // geometry: 6 columns, 4 displayed, 2 raster lines, 2 rows, start 0x1FC
    wr_reg(5'd0, 8'd5);
    wr_reg(5'd1, 8'd4);
    wr_reg(5'd6, 8'd2);
    wr_reg(5'd9, 8'd1);
    wr_reg(5'd12, 8'h41);
    wr_reg(5'd13, 8'hFC);
    cyc(8'h70, 1'b1, 8'h01, 1'b0, 1'b0);

    // R5: frame start wins over char enable in the same cycle
    cyc(8'h00, 1'b0, 8'h00, 1'b1, 1'b1);
    chk("R5", "vaddr after frame start", 32'(vaddr_o), 32'h073C);
    chk("R5", "ra after frame start", 32'(ra_o), 32'h0);

    // R4: ma crosses the 64 boundary inside the displayed row
    cyc(8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    cyc(8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    cyc(8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    cyc(8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    chk("R4", "vaddr past 64 boundary", 32'(vaddr_o), 32'h0800);
    chk("R7", "de low beyond hdisp", 32'(de_o), 32'h0);

    // R10: write register 1 on the edge that ends the last raster line
    for (int k = 0; k < 100; k++) begin
      if (m_col == m_regs[0] && m_ra == m_regs[9][4:0]) break;
      cyc(8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    end
    old_r1 = m_regs[1];
    exp_ma = m_base + {6'd0, old_r1};
    cyc(8'h71, 1'b1, 8'h07, 1'b1, 1'b0);
    chk("R10", "row base uses old reg1", 32'(vaddr_o), 32'(map_addr(exp_ma, 5'd0)));
    chk("R10", "ra wraps", 32'(ra_o), 32'h0);
    cyc(8'h71, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R2", "reg1 new value", 32'(cpu_rdata_o), 32'h07);

    // R6/R7: run a full frame, de drops once row count reaches reg6
    cyc(8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
    for (int k = 0; k < 60; k++) cyc(8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    chk("R7", "de low after last row", 32'(de_o), 32'h0);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] port, wd;
      logic we, ce, fs;
      ce = ($urandom % 10) < 7;
      fs = ($urandom % 100) == 0;
      we = ($urandom % 20) == 0;
      port = {4'h7, 4'($urandom)};
      if (($urandom % 8) == 0) port = 8'($urandom);
      if (port[7:4] == 4'h7 && !port[0]) wd = 8'($urandom % 20);
      else if (m_idx == 5'd12 || m_idx == 5'd13) wd = 8'($urandom);
      else wd = 8'($urandom % 10);
      cyc(port, we, wd, ce, fs);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule